// File: doc/BRIEF.md
# Host Wake Access Handshake Controller

This block sits between a host register port and a power-gated internal processor domain. The host writes one general-purpose control word to ask for the domain to be powered and clocked. It then reads the same word back to learn when the domain can be reached. The block sequences a modelled domain through sleep, waking, ready, draining and fault states. It holds a clock-ready flag low until the host has declared initialisation complete. It grants access only while the domain is up and is not winding down.

The host writes the word on a single-cycle write strobe. The status view is always present on the read-data output. A software-reset strobe drops all host requests and forces the domain back to sleep. A level from an external RF-kill switch is resynchronised and mirrored in the status view. The domain answers wake requests through a ready-acknowledge level. If that acknowledge is lost while the domain is up, the block latches a fault until the next software reset.

Top module: `hwk_wake_ctrl`

## Requirements
- R1: After reset, the read word is 0x0100_0000 with the RF-kill switch low, and clk_ready, going_to_sleep and access_grant are all 0.
- R2: Only bit 2 (init-done) and bit 3 (access request) store host-written values. Writing any other bit leaves the read word unchanged.
- R3: clk_ready stays 0 after reset or software reset until init-done has been written as 1. An access request alone does not wake the domain, even with the acknowledge high.
- R4: Writing init-done moves the domain to waking on the next cycle. clk_ready rises on the first clock edge at which the acknowledge is sampled high while waking.
- R5: Read bit 0 equals clk_ready and read bit 4 equals going_to_sleep.
- R6: Clearing both init-done and the request while ready raises going_to_sleep for exactly SLEEP_CYCLES cycles, starting one cycle after the write. clk_ready stays 1 during that window and falls together with going_to_sleep.
- R7: access_grant is 1 only when clk_ready is 1, going_to_sleep is 0 and the request bit is 1. A request written while going to sleep is not granted.
- R8: Read bits 26:24 give the power-save mode. The code is 000 when ready or going to sleep. While asleep or waking it is 001 with the RF-kill switch low and 010 with it high. It is 011 in fault.
- R9: Read bit 27 follows the RF-kill switch level SYNC_STAGES cycles after the switch changes.
- R10: If the acknowledge is low while ready, the block enters fault on the next edge. clk_ready and access_grant are 0 there, and it stays in fault until a software reset, whatever the acknowledge does.
- R11: A software-reset strobe clears bits 2 and 3 and puts the domain to sleep on the next edge, from any state. It takes priority over a write in the same cycle.
- R12: Once init-done has been written after a reset, the access request alone keeps the domain awake and wakes it again from sleep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr_en | input | 1 | Host write strobe for the control word |
| host_wr_data | input | 32 | Host write data |
| host_rd_data | output | 32 | Control/status read word |
| sw_reset | input | 1 | Software-reset strobe |
| rfkill_in | input | 1 | RF-kill switch level, asynchronous |
| dom_ready_ack | input | 1 | Modelled domain ready acknowledge |
| clk_ready | output | 1 | Domain clocked and accessible |
| going_to_sleep | output | 1 | Domain winding down toward sleep |
| access_grant | output | 1 | Host may touch internal resources |

## Verification
The bench writes each of the 32 one-hot patterns. A block that stored any bit other than 2 or 3 would show the stray bit in the read word. Wake latency is swept over several acknowledge delays, so an early clk_ready or one that ignores the acknowledge is caught. The drain window is counted cycle by cycle, which exposes an off-by-one in the sleep counter. A request written inside that window must not be granted and must rewake the domain afterwards. The bench also drops the acknowledge while ready and then restores it. A design that recovers from fault on its own, or lets a same-cycle write override a software reset, would report the wrong mode or stored bits.

// File: rtl/hwk_pkg.sv
package hwk_pkg;
  localparam int REG_W = 32;

  localparam int BIT_CLK_RDY = 0;
  localparam int BIT_INIT    = 2;
  localparam int BIT_REQ     = 3;
  localparam int BIT_GTS     = 4;
  localparam int PS_LSB      = 24;
  localparam int PS_W        = 3;
  localparam int BIT_RFKILL  = 27;

  localparam logic [PS_W-1:0] PS_NONE  = 3'b000;
  localparam logic [PS_W-1:0] PS_MAC   = 3'b001;
  localparam logic [PS_W-1:0] PS_RADIO = 3'b010;
  localparam logic [PS_W-1:0] PS_ERR   = 3'b011;

  typedef enum logic [2:0] {
    ST_SLEEP  = 3'd0,
    ST_WAKING = 3'd1,
    ST_READY  = 3'd2,
    ST_DRAIN  = 3'd3,
    ST_FAULT  = 3'd4
  } pwr_state_e;
endpackage

// File: rtl/hwk_ctrl_reg.sv
module hwk_ctrl_reg (
  input  logic clk,
  input  logic rst,
  input  logic sw_reset,
  input  logic wr_en,
  input  logic wr_init,
  input  logic wr_req,
  output logic init_done,
  output logic acc_req,
  output logic armed
);
  // Host-owned bits; software reset wins over a same-cycle write.
  always_ff @(posedge clk) begin
    if (rst || sw_reset) begin
      init_done <= 1'b0;
      acc_req   <= 1'b0;
      armed     <= 1'b0;
    end else if (wr_en) begin
      init_done <= wr_init;
      acc_req   <= wr_req;
      if (wr_init) armed <= 1'b1;
    end
  end
endmodule

// File: rtl/hwk_sync.sv
module hwk_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  generate
    if (STAGES <= 1) begin : g_single
      logic s;
      always_ff @(posedge clk) begin
        if (rst) s <= 1'b0;
        else     s <= d;
      end
      assign q = s;
    end else begin : g_chain
      logic [STAGES-1:0] s;
      always_ff @(posedge clk) begin
        if (rst) s <= '0;
        else     s <= {s[STAGES-2:0], d};
      end
      assign q = s[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/hwk_pwr_fsm.sv
module hwk_pwr_fsm
  import hwk_pkg::*;
#(
  parameter int SLEEP_CYCLES = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       sw_reset,
  input  logic       init_done,
  input  logic       acc_req,
  input  logic       armed,
  input  logic       dom_ack,
  output pwr_state_e state,
  output pwr_state_e nxt_state
);
  localparam int CNT_W = (SLEEP_CYCLES > 1) ? $clog2(SLEEP_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(SLEEP_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic keep_awake;

  assign keep_awake = init_done | (acc_req & armed);

  always_comb begin
    nxt_state = state;
    cnt_d     = cnt_q;
    if (sw_reset) begin
      nxt_state = ST_SLEEP;
    end else begin
      unique case (state)
        ST_SLEEP:  if (keep_awake) nxt_state = ST_WAKING;
        ST_WAKING: if (dom_ack) nxt_state = ST_READY;
        ST_READY: begin
          if (!dom_ack) begin
            nxt_state = ST_FAULT;
          end else if (!keep_awake) begin
            nxt_state = ST_DRAIN;
            cnt_d     = CNT_LOAD;
          end
        end
        ST_DRAIN: begin
          if (cnt_q == '0) nxt_state = ST_SLEEP;
          else             cnt_d = cnt_q - 1'b1;
        end
        ST_FAULT:  nxt_state = ST_FAULT;
        default:   nxt_state = ST_SLEEP;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_SLEEP;
      cnt_q <= '0;
    end else begin
      state <= nxt_state;
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/hwk_status_out.sv
module hwk_status_out
  import hwk_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  pwr_state_e       state,
  input  pwr_state_e       nxt_state,
  input  logic             rf_sync,
  input  logic             init_done,
  input  logic             acc_req,
  output logic             clk_ready,
  output logic             going_to_sleep,
  output logic             access_grant,
  output logic [REG_W-1:0] rd_data
);
  logic [PS_W-1:0] ps_code;

  always_ff @(posedge clk) begin
    if (rst) begin
      clk_ready      <= 1'b0;
      going_to_sleep <= 1'b0;
    end else begin
      clk_ready      <= (nxt_state == ST_READY) || (nxt_state == ST_DRAIN);
      going_to_sleep <= (nxt_state == ST_DRAIN);
    end
  end

  always_comb begin
    unique case (state)
      ST_READY, ST_DRAIN: ps_code = PS_NONE;
      ST_FAULT:           ps_code = PS_ERR;
      default:            ps_code = rf_sync ? PS_RADIO : PS_MAC;
    endcase
  end

  assign access_grant = clk_ready & ~going_to_sleep & acc_req;

  always_comb begin
    rd_data = '0;
    rd_data[BIT_CLK_RDY]            = clk_ready;
    rd_data[BIT_INIT]               = init_done;
    rd_data[BIT_REQ]                = acc_req;
    rd_data[BIT_GTS]                = going_to_sleep;
    rd_data[PS_LSB +: PS_W]         = ps_code;
    rd_data[BIT_RFKILL]             = rf_sync;
  end
endmodule

// File: rtl/hwk_wake_ctrl.sv
module hwk_wake_ctrl
  import hwk_pkg::*;
#(
  parameter int SLEEP_CYCLES = 8,
  parameter int SYNC_STAGES  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             host_wr_en,
  input  logic [REG_W-1:0] host_wr_data,
  output logic [REG_W-1:0] host_rd_data,
  input  logic             sw_reset,
  input  logic             rfkill_in,
  input  logic             dom_ready_ack,
  output logic             clk_ready,
  output logic             going_to_sleep,
  output logic             access_grant
);
  logic       init_done, acc_req, armed, rf_sync;
  pwr_state_e state, nxt_state;
  logic       unused_wr_bits;

  assign unused_wr_bits = ^{host_wr_data[REG_W-1:BIT_REQ+1], host_wr_data[BIT_INIT-1:0]};

  hwk_ctrl_reg u_reg (
    .clk(clk), .rst(rst), .sw_reset(sw_reset), .wr_en(host_wr_en),
    .wr_init(host_wr_data[BIT_INIT]), .wr_req(host_wr_data[BIT_REQ]),
    .init_done(init_done), .acc_req(acc_req), .armed(armed)
  );

  hwk_sync #(.STAGES(SYNC_STAGES)) u_rf_sync (
    .clk(clk), .rst(rst), .d(rfkill_in), .q(rf_sync)
  );

  hwk_pwr_fsm #(.SLEEP_CYCLES(SLEEP_CYCLES)) u_fsm (
    .clk(clk), .rst(rst), .sw_reset(sw_reset), .init_done(init_done),
    .acc_req(acc_req), .armed(armed), .dom_ack(dom_ready_ack),
    .state(state), .nxt_state(nxt_state)
  );

  hwk_status_out u_out (
    .clk(clk), .rst(rst), .state(state), .nxt_state(nxt_state),
    .rf_sync(rf_sync), .init_done(init_done), .acc_req(acc_req),
    .clk_ready(clk_ready), .going_to_sleep(going_to_sleep),
    .access_grant(access_grant), .rd_data(host_rd_data)
  );
endmodule

// File: rtl/hwk_wake_ctrl_chk.sv
module hwk_wake_ctrl_chk #(
  parameter int SLEEP_CYCLES = 8
) (
  input logic        clk,
  input logic        rst,
  input logic        sw_reset,
  input logic        dom_ready_ack,
  input logic [31:0] host_rd_data,
  input logic        clk_ready,
  input logic        going_to_sleep,
  input logic        access_grant
);
  localparam int RUN_W = $clog2(SLEEP_CYCLES + 2) + 1;
  localparam logic [RUN_W-1:0] RUN_MAX = '1;
  localparam logic [RUN_W-1:0] RUN_LIM = RUN_W'(SLEEP_CYCLES);

  logic [RUN_W-1:0] run;
  always_ff @(posedge clk) begin
    if (rst)                                  run <= '0;
    else if (!going_to_sleep)                 run <= '0;
    else if (run != RUN_MAX)                  run <= run + 1'b1;
  end

  p_grant_safe_r7: assert property (@(posedge clk) disable iff (rst)
    access_grant |-> (clk_ready && !going_to_sleep));

  p_gts_ready_r6: assert property (@(posedge clk) disable iff (rst)
    going_to_sleep |-> clk_ready);

  p_run_cap_r6: assert property (@(posedge clk) disable iff (rst)
    run <= RUN_LIM);

  p_drain_len_r6: assert property (@(posedge clk) disable iff (rst)
    ($fell(going_to_sleep) && !$past(sw_reset)) |-> (run == RUN_LIM));

  p_swrst_r11: assert property (@(posedge clk) disable iff (rst)
    sw_reset |=> (!clk_ready && host_rd_data[3:2] == 2'b00));

  p_ready_ack_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(clk_ready) |-> $past(dom_ready_ack));

  p_ps_ready_r8: assert property (@(posedge clk) disable iff (rst)
    clk_ready |-> (host_rd_data[26:24] == 3'b000));

  p_fault_r10: assert property (@(posedge clk) disable iff (rst)
    (host_rd_data[26:24] == 3'b011) |-> (!clk_ready && !access_grant));
endmodule

bind hwk_wake_ctrl hwk_wake_ctrl_chk #(.SLEEP_CYCLES(SLEEP_CYCLES)) u_chk (
  .clk(clk), .rst(rst), .sw_reset(sw_reset), .dom_ready_ack(dom_ready_ack),
  .host_rd_data(host_rd_data), .clk_ready(clk_ready),
  .going_to_sleep(going_to_sleep), .access_grant(access_grant)
);

// File: tb/tb_hwk_wake_ctrl.sv
module tb_hwk_wake_ctrl;
  localparam int NSLP = 3;
  localparam int NSYNC = 2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        host_wr_en = 1'b0;
  logic [31:0] host_wr_data = '0;
  logic [31:0] host_rd_data;
  logic        sw_reset = 1'b0;
  logic        rfkill_in = 1'b0;
  logic        dom_ready_ack = 1'b0;
  logic        clk_ready, going_to_sleep, access_grant;

  int nchk = 0;
  int nerr = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  hwk_wake_ctrl #(.SLEEP_CYCLES(NSLP), .SYNC_STAGES(NSYNC)) dut (
    .clk(clk), .rst(rst), .host_wr_en(host_wr_en), .host_wr_data(host_wr_data),
    .host_rd_data(host_rd_data), .sw_reset(sw_reset), .rfkill_in(rfkill_in),
    .dom_ready_ack(dom_ready_ack), .clk_ready(clk_ready),
    .going_to_sleep(going_to_sleep), .access_grant(access_grant)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] v);
    host_wr_en = 1'b1;
    host_wr_data = v;
    tick();
    host_wr_en = 1'b0;
    host_wr_data = '0;
  endtask

  task automatic swrst();
    sw_reset = 1'b1;
    tick();
    sw_reset = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nerr++;
      nchk++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    repeat (4) tick();
    rst = 1'b0;
    tick();
    // R1 reset view
    chk("R1 rd", host_rd_data, 32'h0100_0000);
    chk("R1 flags", {29'd0, clk_ready, going_to_sleep, access_grant}, 32'd0);

    // R2 one-hot write sweep, R11 software reset clears
    for (int b = 0; b < 32; b++) begin
      logic [31:0] e;
      e = 32'h0100_0000 | ((b == 2) ? 32'h4 : 32'h0) | ((b == 3) ? 32'h8 : 32'h0);
      wr(32'h1 << b);
      chk("R2 stored bits", host_rd_data, e);
      swrst();
      chk("R11 cleared", host_rd_data, 32'h0100_0000);
    end

    // R3 request alone does not wake
    dom_ready_ack = 1'b1;
    wr(32'h8);
    repeat (4) tick();
    chk("R3 no wake", {31'd0, clk_ready}, 32'd0);
    swrst();

    // R4/R5/R6/R7/R8 sweep over acknowledge delay
    for (int d = 0; d < 5; d++) begin
      dom_ready_ack = 1'b0;
      wr(32'h4);
      tick();
      for (int k = 0; k < d; k++) begin
        tick();
        chk("R4 waiting", {31'd0, clk_ready}, 32'd0);
      end
      chk("R3 before ack", {31'd0, clk_ready}, 32'd0);
      dom_ready_ack = 1'b1;
      tick();
      chk("R4 ready", {31'd0, clk_ready}, 32'd1);
      chk("R5 bit0", {31'd0, host_rd_data[0]}, 32'd1);
      wr(32'hC);
      chk("R7 grant", {31'd0, access_grant}, 32'd1);
      wr(32'h0);
      chk("R7 no req", {31'd0, access_grant}, 32'd0);
      chk("R6 still up", {31'd0, clk_ready}, 32'd1);
      for (int i = 1; i <= NSLP; i++) begin
        tick();
        chk("R6 gts", {30'd0, clk_ready, going_to_sleep}, 32'd3);
        chk("R5 bit4", {31'd0, host_rd_data[4]}, 32'd1);
        chk("R8 none", {29'd0, host_rd_data[26:24]}, 32'd0);
      end
      tick();
      chk("R6 asleep", {30'd0, clk_ready, going_to_sleep}, 32'd0);
      chk("R8 mac", {29'd0, host_rd_data[26:24]}, 32'd1);
    end

    // R12 request alone after arming; R7 request during drain
    wr(32'h8);
    tick();
    tick();
    chk("R12 awake", {30'd0, clk_ready, access_grant}, 32'd3);
    wr(32'h0);
    tick();
    chk("R6 drain", {31'd0, going_to_sleep}, 32'd1);
    wr(32'h8);
    chk("R7 drain no grant", {30'd0, going_to_sleep, access_grant}, 32'd2);
    tick();
    chk("R7 drain no grant2", {30'd0, going_to_sleep, access_grant}, 32'd2);
    tick();
    chk("R6 slept", {31'd0, clk_ready}, 32'd0);
    tick();
    chk("R12 waking", {31'd0, clk_ready}, 32'd0);
    tick();
    chk("R12 rewake", {30'd0, clk_ready, access_grant}, 32'd3);

    // R10 fault
    dom_ready_ack = 1'b0;
    tick();
    chk("R10 down", {30'd0, clk_ready, access_grant}, 32'd0);
    chk("R10 mode", {29'd0, host_rd_data[26:24]}, 32'd3);
    dom_ready_ack = 1'b1;
    repeat (3) tick();
    chk("R10 sticky", {29'd0, host_rd_data[26:24]}, 32'd3);
    chk("R10 sticky clk", {31'd0, clk_ready}, 32'd0);
    sw_reset = 1'b1;
    host_wr_en = 1'b1;
    host_wr_data = 32'hC;
    tick();
    sw_reset = 1'b0;
    host_wr_en = 1'b0;
    host_wr_data = '0;
    chk("R11 priority", host_rd_data, 32'h0100_0000);
    repeat (3) tick();
    chk("R11 asleep", {31'd0, clk_ready}, 32'd0);

    // R9 RF-kill mirror and R8 radio mode
    rfkill_in = 1'b1;
    tick();
    chk("R9 lag", {31'd0, host_rd_data[27]}, 32'd0);
    tick();
    chk("R9 mirror", {31'd0, host_rd_data[27]}, 32'd1);
    chk("R8 radio", {29'd0, host_rd_data[26:24]}, 32'd2);
    rfkill_in = 1'b0;
    tick();
    tick();
    chk("R9 clear", {31'd0, host_rd_data[27]}, 32'd0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule